// File: doc/BRIEF.md
# Watchdog Timer with Keyed Enable

This block is a watchdog for a small controller. It counts ticks from one of three time bases. The ticks pass first through a power-of-two prescaler and then into an 8-bit timeout counter. When that counter overflows, the block emits a one-cycle reset pulse. Software must strobe a clear input often enough to keep the counter from overflowing.

The watchdog can be switched off in only one way. A 4-bit key field must hold a single magic value, and the static force-enable configuration input must be low. Any other key value turns the watchdog on. Everything runs on one system clock. Each time base arrives as a one-cycle tick enable.

Software uses a small write port for two fields: the key and the prescaler select. Two static configuration inputs choose the time base and can force the watchdog on.

Top module: `wdog_keyed`

## Requirements
- R1: After synchronous reset, `wdt_rst` is low, the key field holds 4'b1010, the prescaler select holds 3'b000, and so the watchdog is off unless `cfg_force_en` is high.
- R2: The watchdog is off exactly when the key field equals 4'b1010 and `cfg_force_en` is low. A write with `wr_en`=1 and `wr_addr`=0 loads `wr_data` into the key field. While the watchdog is off, `wdt_rst` never pulses.
- R3: `cfg_src` selects the counted tick: 2'b00 selects `tick_xtal`, 2'b01 selects `tick_sys4`, and 2'b10 or 2'b11 selects `tick_irc`. Ticks on unselected inputs are not counted.
- R4: While `sleep` is high, `tick_sys4` is not counted. The other two sources keep counting during sleep. Counting resumes from where it stopped when sleep ends.
- R5: A write with `wr_addr`=1 loads `wr_data[2:0]` into the prescaler select S. The timeout is 256·2^S counted ticks. `wdt_rst` is high in the cycle after the clock edge that samples the last tick of the timeout.
- R6: `wdt_rst` lasts exactly one cycle. The prescaler and counter restart from zero, so an undisturbed watchdog pulses once every 256·2^S ticks.
- R7: A `sw_clear` strobe while the watchdog is on zeroes the prescaler and the counter. If the strobe arrives on the same edge as the overflowing tick, the clear wins and no pulse occurs.
- R8: While the watchdog is off, the prescaler and counter are held at zero and `sw_clear` has no effect. After re-enabling, a full 256·2^S ticks pass before a pulse.
- R9: Writing the prescaler select zeroes the prescaler but leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_force_en | input | 1 | Static configuration: forces the watchdog on |
| cfg_src | input | 2 | Static configuration: time base select |
| tick_xtal | input | 1 | Tick enable from the low-speed crystal |
| tick_sys4 | input | 1 | Tick enable from system clock divided by 4 |
| tick_irc | input | 1 | Tick enable from the low-speed internal oscillator |
| sleep | input | 1 | Sleep indication; suppresses the system-divided source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = key field, 1 = prescaler select |
| wr_data | input | 4 | Write data |
| sw_clear | input | 1 | Software clear strobe |
| wdt_rst | output | 1 | One-cycle reset pulse on overflow |

## Verification
A wrong count in the prescaler or counter changes the time at which `wdt_rst` rises. So the bench checks every cycle of each window and compares the pulse position to the exact tick index computed from the requirements. An off-by-one error therefore shows up within a single timeout period. A failure to hold the counter at zero while the watchdog is off, or a failure of a clear or a select write to zero the prescaler, moves the next pulse earlier than a full period after the event. A pulse that lasts too long, or that fires while the watchdog is off, is caught in the very cycle it appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_SYS4 = 2'b01,
    SRC_IRC  = 2'b10,
    SRC_IRC2 = 2'b11
  } src_e;

  localparam logic ADDR_KEY = 1'b0;
  localparam logic ADDR_PS  = 1'b1;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_i,
  input  logic       tick_xtal_i,
  input  logic       tick_sys4_i,
  input  logic       tick_irc_i,
  input  logic       sleep_i,
  output logic       tick_o
);
  src_e src;
  assign src = src_e'(src_i);

  always_comb begin
    unique case (src)
      SRC_XTAL: tick_o = tick_xtal_i;
      SRC_SYS4: tick_o = tick_sys4_i & ~sleep_i;
      default:  tick_o = tick_irc_i;
    endcase
  end

  // R4: the divided system source is silent during sleep
  p_sleep_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (src_i == 2'b01 && sleep_i) |-> !tick_o);
  // R3: no tick reaches the prescaler unless the selected line ticks
  p_src_only_r3: assert property (@(posedge clk) disable iff (rst)
    (src_i == 2'b00 && !tick_xtal_i) |-> !tick_o);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W = 3,
  localparam int PS_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < PS_W; b++) mask[b] = (b < int'(sel_i));
  end

  assign step_o = tick_i && (cnt_q == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (step_o)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + PS_W'(1);
  end

  // R9: a clear leaves the prescaler empty
  p_ps_zero_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  // R5: without a tick the prescaler holds
  p_ps_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = step_i && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R8: cleared or disabled state leaves the counter at zero
  p_held_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  // R5: counter only moves on a prescaler step
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter int SEL_W = 3,
  parameter int CNT_W = 8,
  parameter logic [KEY_W-1:0] KEY_OFF = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_force_en,
  input  logic [1:0]       cfg_src,
  input  logic             tick_xtal,
  input  logic             tick_sys4,
  input  logic             tick_irc,
  input  logic             sleep,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             sw_clear,
  output logic             wdt_rst
);
  logic [KEY_W-1:0] key_q;
  logic [SEL_W-1:0] sel_q;
  logic             rst_q;
  logic             wdt_on, tick, step, ovf;
  logic             wr_sel, clr_cnt, clr_ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= KEY_OFF;
      sel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_KEY) key_q <= wr_data;
      else                     sel_q <= wr_data[SEL_W-1:0];
    end
  end

  assign wdt_on  = cfg_force_en || (key_q != KEY_OFF);
  assign wr_sel  = wr_en && (wr_addr == ADDR_PS);
  assign clr_cnt = !wdt_on || sw_clear;
  assign clr_ps  = clr_cnt || wr_sel || ovf;

  wdog_tick_sel u_sel (
    .clk(clk), .rst(rst), .src_i(cfg_src),
    .tick_xtal_i(tick_xtal), .tick_sys4_i(tick_sys4), .tick_irc_i(tick_irc),
    .sleep_i(sleep), .tick_o(tick)
  );

  wdog_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst(rst), .clr_i(clr_ps), .tick_i(tick),
    .sel_i(sel_q), .step_o(step)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(clr_cnt), .step_i(step), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_q <= 1'b0;
    else     rst_q <= wdt_on && ovf && !sw_clear;
  end
  assign wdt_rst = rst_q;

  // R6: pulse lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst);
  // R2: no pulse while off
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !wdt_on |=> !wdt_rst);
  // R7: a clear strobe suppresses the next pulse
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    sw_clear |=> !wdt_rst);
endmodule

// File: tb/wdog_keyed_tb.sv
`timescale 1ns/1ps
module wdog_keyed_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_force_en = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic tick_xtal = 1'b0, tick_sys4 = 1'b0, tick_irc = 1'b0;
  logic sleep = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic sw_clear = 1'b0;
  logic wdt_rst;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_keyed u_dut (
    .clk(clk), .rst(rst), .cfg_force_en(cfg_force_en), .cfg_src(cfg_src),
    .tick_xtal(tick_xtal), .tick_sys4(tick_sys4), .tick_irc(tick_irc),
    .sleep(sleep), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_clear(sw_clear), .wdt_rst(wdt_rst)
  );

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] line;
    logic [3:0] key;
    logic [2:0] ps;
    logic       force_en;
    logic       slp;
    logic       fire;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{2'd0, 2'd0, 4'h5, 3'd0, 1'b0, 1'b0, 1'b1},  // R3 R5 crystal
    '{2'd1, 2'd1, 4'h0, 3'd2, 1'b0, 1'b0, 1'b1},  // R2 R3 sys/4
    '{2'd2, 2'd2, 4'hF, 3'd3, 1'b0, 1'b0, 1'b1},  // R3 internal
    '{2'd0, 2'd1, 4'h5, 3'd1, 1'b0, 1'b0, 1'b0},  // R3 wrong line
    '{2'd1, 2'd1, 4'h5, 3'd0, 1'b0, 1'b1, 1'b0},  // R4 sys/4 asleep
    '{2'd3, 2'd2, 4'h5, 3'd1, 1'b0, 1'b1, 1'b1},  // R3 R4 internal asleep
    '{2'd0, 2'd0, 4'h5, 3'd0, 1'b0, 1'b1, 1'b1},  // R4 crystal asleep
    '{2'd0, 2'd0, 4'hA, 3'd0, 1'b0, 1'b0, 1'b0},  // R2 keyed off
    '{2'd0, 2'd0, 4'hA, 3'd0, 1'b1, 1'b0, 1'b1},  // R2 forced on
    '{2'd2, 2'd2, 4'h5, 3'd7, 1'b0, 1'b0, 1'b1}   // R5 longest
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic set_line(input int line, input logic v);
    tick_xtal = (line == 0) ? v : 1'b0;
    tick_sys4 = (line == 1) ? v : 1'b0;
    tick_irc  = (line == 2) ? v : 1'b0;
  endtask

  // n ticks on one line; a pulse is expected right after tick k exactly when
  // period > 0 and k is a multiple of period (k <= n)
  task automatic run_ticks(input int line, input int n, input int period,
                           input string req);
    int first_bad = -1;
    int act = 0, exp = 0;
    for (int i = 0; i <= n + 2; i++) begin
      @(negedge clk);
      begin
        logic e;
        e = (period > 0) && (i > 0) && (i <= n) && (i % period == 0);
        if (wdt_rst !== e && first_bad < 0) begin
          first_bad = i; act = int'(wdt_rst); exp = int'(e);
        end
      end
      set_line(line, i < n);
    end
    set_line(0, 1'b0);
    check(first_bad < 0, req, $sformatf("pulse at tick %0d", first_bad), act, exp);
  endtask

  initial begin
    #(1ms);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wdt_rst === 1'b0, "R1", "reset output", int'(wdt_rst), 0);
    run_ticks(0, 300, 0, "R1");  // default key keeps it off

    foreach (VEC[k]) begin
      int nt;
      cfg_src = VEC[k].src; cfg_force_en = VEC[k].force_en; sleep = VEC[k].slp;
      wr(1'b0, VEC[k].key);
      wr(1'b1, {1'b0, VEC[k].ps});
      clear_pulse();
      nt = 256 << VEC[k].ps;
      if (VEC[k].fire) run_ticks(int'(VEC[k].line), nt, nt, "R5 vector");
      else             run_ticks(int'(VEC[k].line), nt + 5, 0, "R3 vector");
    end
    cfg_force_en = 1'b0; sleep = 1'b0; cfg_src = 2'b00;
    wr(1'b0, 4'h5); wr(1'b1, 4'h0); clear_pulse();

    // R7 clear restarts the timeout
    run_ticks(0, 200, 0, "R7");
    clear_pulse();
    run_ticks(0, 256, 256, "R7");

    // R7 clear on the overflowing edge wins
    run_ticks(0, 255, 0, "R7");
    @(negedge clk); tick_xtal = 1'b1; sw_clear = 1'b1;
    @(negedge clk); tick_xtal = 1'b0; sw_clear = 1'b0;
    check(wdt_rst === 1'b0, "R7", "clear vs overflow", int'(wdt_rst), 0);
    run_ticks(0, 256, 256, "R7");

    // R8 disabled holds zero, clear ignored
    run_ticks(0, 200, 0, "R8");
    wr(1'b0, 4'hA);
    clear_pulse();
    check(wdt_rst === 1'b0, "R8", "clear while off", int'(wdt_rst), 0);
    run_ticks(0, 300, 0, "R8");
    wr(1'b0, 4'h5);
    run_ticks(0, 256, 256, "R8");

    // R9 select write zeroes only the prescaler
    wr(1'b1, 4'h3); clear_pulse();
    run_ticks(0, 4, 0, "R9");
    wr(1'b1, 4'h3);
    run_ticks(0, 2048, 2048, "R9");

    // R6 periodic pulses
    wr(1'b1, 4'h0); clear_pulse();
    run_ticks(0, 768, 256, "R6");

    // R4 sleep pauses the divided source, then resumes
    cfg_src = 2'b01; clear_pulse();
    run_ticks(1, 100, 0, "R4");
    sleep = 1'b1;
    run_ticks(1, 100, 0, "R4");
    sleep = 1'b0;
    run_ticks(1, 156, 156, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule